// File: doc/BRIEF.md
# Receive Line Break Detector

This block watches the synchronised receive line of a serial port. It raises an alarm when the line stays low for longer than a set number of character times. The character time is worked out in clock cycles from the baud divisor, the word length, the parity enable and the stop-bit count. The block recomputes it whenever any of these settings changes. The detection threshold is a parameterised multiple of that character time.

When the low time passes the threshold, the block reports the break once. It issues a single-cycle push request toward the receive FIFO. The pushed entry has an all-zero data byte, and its upper byte carries the status flags that describe the break. In the same cycle it pulses an abort, so that the receive shift stage drops any partly assembled character and resets its bit counter.

A latch stops further reports while the line stays low. When the latch sees the threshold passed again, the duration counter restarts. The latch clears as soon as the line returns high, which re-arms the detector for the next break.

Top module: `rx_break_detect`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `push_valid`, `abort_rx` and `break_active` are 0 and `push_word` is 0.
- R2: The character time in clocks is `divisor * OVERSAMPLE * (7 + word_len + parity_en + two_stop)`. Here `word_len` 0..3 selects 5..8 data bits. The threshold T is `BREAK_CHARS` times that value. The defaults are OVERSAMPLE=16 and BREAK_CHARS=2.
- R3: A break is reported only if `rx_line` is sampled low on at least T+2 consecutive rising edges. `push_valid` is then high for exactly one cycle, which follows the (T+2)-th low edge. With T+1 low edges there is no report.
- R4: The pushed word has bits [7:0] equal to 0. Its flag byte [15:8] has bit 0 (data ready), bit 3 (framing), bit 4 (break) and bit 7 (receive error) set. Bit 2 (parity error) is set only if `parity_en` is 1. This gives 16'h9900, or 16'h9D00 with parity enabled.
- R5: `abort_rx` pulses high in exactly the cycles in which `push_valid` is high.
- R6: However long the line stays low, at most one push is made per break.
- R7: One rising edge with `rx_line` high clears `break_active`. A following break of at least T+2 low edges is reported again.
- R8: A change of `divisor`, `word_len`, `parity_en` or `two_stop` made while the line is idle sets the threshold used by the next break.
- R9: `break_active` goes high in the same cycle as the push. It stays high until the line returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Synchronised receive line level |
| divisor | input | DIV_W | Baud rate divisor |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in each frame |
| two_stop | input | 1 | Two stop bits instead of one |
| push_valid | output | 1 | One-cycle request to write `push_word` into the receive FIFO |
| push_word | output | 16 | Zero data byte with the break flag byte above it |
| abort_rx | output | 1 | Discard the partial character and reset the bit counter |
| break_active | output | 1 | A break has been reported and the line is still low |

## Verification
The checker assumes that `rx_line` is already synchronised to `clk`. It also assumes that the settings that form the character time stay still while the line is low, because a change in mid-break moves the threshold under a running count. The stimulus changes `divisor`, `word_len`, `parity_en` and `two_stop` only while the line is high, and it waits several idle cycles before each break. All line changes are driven on the falling clock edge, so every low interval is an exact count of rising edges.

// File: rtl/rx_break_pkg.sv
package rx_break_pkg;

    localparam int FLAG_DATA_READY = 0;
    localparam int FLAG_PARITY     = 2;
    localparam int FLAG_FRAMING    = 3;
    localparam int FLAG_BREAK      = 4;
    localparam int FLAG_RX_ERROR   = 7;

    localparam int WORD_W = 16;

    typedef struct packed {
        logic        dummy;
    } unused_t;

endpackage

// File: rtl/rx_break_char_time.sv
module rx_break_char_time #(
    parameter int DIV_W       = 16,
    parameter int OVERSAMPLE  = 16,
    parameter int BREAK_CHARS = 2,
    parameter int CHAR_W      = DIV_W + $clog2(OVERSAMPLE) + 5,
    parameter int THR_W       = CHAR_W + $clog2(BREAK_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    output logic [THR_W-1:0] threshold
);

    localparam int CFG_W = DIV_W + 4;

    typedef struct packed {
        logic              valid;
        logic [CFG_W-1:0]  cfg;
        logic [THR_W-1:0]  thr;
    } ct_state_t;

    ct_state_t st_d, st_q;
    logic [CFG_W-1:0] cfg_now;
    logic [3:0]       frame_bits;
    logic [CHAR_W-1:0] char_clks;

    assign cfg_now = {divisor, word_len, parity_en, two_stop};

    always_comb begin
        frame_bits = 4'd7 + {2'b00, word_len} + {3'b000, parity_en} + {3'b000, two_stop};
        char_clks  = CHAR_W'(divisor) * CHAR_W'(OVERSAMPLE) * CHAR_W'(frame_bits);
        st_d = st_q;
        if (!st_q.valid || (cfg_now != st_q.cfg)) begin
            st_d.valid = 1'b1;
            st_d.cfg   = cfg_now;
            st_d.thr   = THR_W'(char_clks) * THR_W'(BREAK_CHARS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign threshold = st_q.thr;

endmodule

// File: rtl/rx_break_flag_encode.sv
module rx_break_flag_encode
    import rx_break_pkg::*;
(
    input  logic              parity_en,
    output logic [WORD_W-1:0] word
);

    logic [7:0] flags;

    always_comb begin
        flags = '0;
        flags[FLAG_DATA_READY] = 1'b1;
        flags[FLAG_FRAMING]    = 1'b1;
        flags[FLAG_BREAK]      = 1'b1;
        flags[FLAG_RX_ERROR]   = 1'b1;
        flags[FLAG_PARITY]     = parity_en;
        word = {flags, 8'h00};
    end

endmodule

// File: rtl/rx_break_detect.sv
module rx_break_detect
    import rx_break_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OVERSAMPLE  = 16,
    parameter int BREAK_CHARS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              two_stop,
    output logic              push_valid,
    output logic [WORD_W-1:0] push_word,
    output logic              abort_rx,
    output logic              break_active
);

    localparam int CHAR_W = DIV_W + $clog2(OVERSAMPLE) + 5;
    localparam int THR_W  = CHAR_W + $clog2(BREAK_CHARS + 1);
    localparam int CNT_W  = THR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              latched;
        logic              push;
        logic              abort;
        logic [WORD_W-1:0] word;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [THR_W-1:0]  threshold;
    logic [WORD_W-1:0] flag_word;

    rx_break_char_time #(
        .DIV_W       (DIV_W),
        .OVERSAMPLE  (OVERSAMPLE),
        .BREAK_CHARS (BREAK_CHARS),
        .CHAR_W      (CHAR_W),
        .THR_W       (THR_W)
    ) char_time_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor   (divisor),
        .word_len  (word_len),
        .parity_en (parity_en),
        .two_stop  (two_stop),
        .threshold (threshold)
    );

    rx_break_flag_encode flag_enc_i (
        .parity_en (parity_en),
        .word      (flag_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.push  = 1'b0;
        st_d.abort = 1'b0;
        st_d.word  = '0;
        if (rx_line) begin
            st_d.cnt     = '0;
            st_d.latched = 1'b0;
        end else if (st_q.cnt > CNT_W'(threshold)) begin
            if (!st_q.latched) begin
                st_d.latched = 1'b1;
                st_d.push    = 1'b1;
                st_d.abort   = 1'b1;
                st_d.word    = flag_word;
                st_d.cnt     = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_valid   = st_q.push;
    assign push_word    = st_q.word;
    assign abort_rx     = st_q.abort;
    assign break_active = st_q.latched;

endmodule

// File: rtl/rx_break_detect_chk.sv
module rx_break_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_line,
    input logic        parity_en,
    input logic        push_valid,
    input logic [15:0] push_word,
    input logic        abort_rx,
    input logic        break_active
);

    AST_ABORT_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        abort_rx == push_valid);  // R5

    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);  // R3

    AST_PUSH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !$past(rx_line));  // R3

    AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (push_word[7:0] == 8'h00 && push_word[15:8] == 8'h99 && !$past(parity_en))
                    || (push_word[7:0] == 8'h00 && push_word[15:8] == 8'h9D && $past(parity_en)));  // R4

    AST_SINGLE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (break_active && $past(break_active)) |-> !push_valid);  // R6

    AST_REARM_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_line |=> !break_active);  // R7

    AST_ACTIVE_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_active) |-> push_valid);  // R9

endmodule

bind rx_break_detect rx_break_detect_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_line      (rx_line),
    .parity_en    (parity_en),
    .push_valid   (push_valid),
    .push_word    (push_word),
    .abort_rx     (abort_rx),
    .break_active (break_active)
);

// File: tb/rx_break_detect_tb.sv
module rx_break_detect_tb_top;

    localparam int DIV_W = 16;
    localparam int OVS   = 16;
    localparam int MULT  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_line = 1'b1;
    logic [DIV_W-1:0] divisor = 16'd1;
    logic [1:0]       word_len = 2'd0;
    logic             parity_en = 1'b0;
    logic             two_stop = 1'b0;
    logic             push_valid;
    logic [15:0]      push_word;
    logic             abort_rx;
    logic             break_active;

    int n_tests = 0;
    int n_fail  = 0;
    int push_cnt = 0;
    int abort_cnt = 0;
    logic [15:0] last_word = '0;

    always #2.5 clk = ~clk;

    rx_break_detect #(.DIV_W(DIV_W), .OVERSAMPLE(OVS), .BREAK_CHARS(MULT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_line      (rx_line),
        .divisor      (divisor),
        .word_len     (word_len),
        .parity_en    (parity_en),
        .two_stop     (two_stop),
        .push_valid   (push_valid),
        .push_word    (push_word),
        .abort_rx     (abort_rx),
        .break_active (break_active)
    );

    always @(negedge clk) begin
        if (push_valid) begin
            push_cnt  = push_cnt + 1;
            last_word = push_word;
        end
        if (abort_rx) abort_cnt = abort_cnt + 1;
    end

    typedef struct packed {
        logic [15:0] div;
        logic [1:0]  wl;
        logic        par;
        logic        st2;
        int          extra;
        int          exp_cnt;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'd1, 2'd0, 1'b0, 1'b0, 1,   0},   // R3 one edge short
        '{16'd1, 2'd0, 1'b0, 1'b0, 2,   1},   // R3 just long enough
        '{16'd1, 2'd3, 1'b1, 1'b0, 2,   1},   // R4 parity flag
        '{16'd2, 2'd3, 1'b1, 1'b1, 2,   1},   // R2 R8 new settings
        '{16'd2, 2'd3, 1'b1, 1'b1, 1,   0},   // R8 short under new settings
        '{16'd1, 2'd1, 1'b0, 1'b1, 900, 1},   // R6 long low
        '{16'd3, 2'd2, 1'b0, 1'b0, 5,   1}    // R2
    };

    function automatic int thr_of(input int d, input int wl, input int p, input int s);
        return MULT * d * OVS * (7 + wl + p + s);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic low_for(input int edges);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int t;
        repeat (3) @(negedge clk);
        check("R1 push in reset", {31'd0, push_valid}, 32'd0);
        check("R1 active in reset", {31'd0, break_active}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {push_word, 13'd0, push_valid, abort_rx, break_active}, 32'd0);
        repeat (3) @(negedge clk);

        foreach (VECS[i]) begin
            divisor   = VECS[i].div;
            word_len  = VECS[i].wl;
            parity_en = VECS[i].par;
            two_stop  = VECS[i].st2;
            repeat (4) @(negedge clk);
            push_cnt = 0;
            abort_cnt = 0;
            last_word = '0;
            t = thr_of(VECS[i].div, VECS[i].wl, VECS[i].par, VECS[i].st2);
            low_for(t + VECS[i].extra);
            check($sformatf("R3 R6 push count vec%0d", i), push_cnt, VECS[i].exp_cnt);
            check($sformatf("R5 abort count vec%0d", i), abort_cnt, VECS[i].exp_cnt);
            if (VECS[i].exp_cnt != 0)
                check($sformatf("R4 word vec%0d", i), last_word, VECS[i].par ? 32'h9D00 : 32'h9900);
            check($sformatf("R7 idle clears vec%0d", i), {31'd0, break_active}, 32'd0);
        end

        // Exact timing with default settings
        divisor = 16'd1; word_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
        repeat (4) @(negedge clk);
        t = thr_of(1, 0, 0, 0);
        rx_line = 1'b0;
        repeat (t + 1) @(posedge clk);
        @(negedge clk);
        check("R3 no push at T+1", {31'd0, push_valid}, 32'd0);
        @(negedge clk);
        check("R3 push at T+2", {31'd0, push_valid}, 32'd1);
        check("R5 abort with push", {31'd0, abort_rx}, 32'd1);
        check("R9 active with push", {31'd0, break_active}, 32'd1);
        check("R4 word no parity", {16'd0, push_word}, 32'h9900);
        @(negedge clk);
        check("R3 push one cycle", {31'd0, push_valid}, 32'd0);
        repeat (t * 3) @(negedge clk);
        check("R9 active while low", {31'd0, break_active}, 32'd1);
        rx_line = 1'b1;
        @(negedge clk);
        check("R7 cleared after one high edge", {31'd0, break_active}, 32'd0);
        push_cnt = 0;
        rx_line = 1'b0;
        repeat (t + 2) @(posedge clk);
        @(negedge clk);
        check("R7 rearmed break reported", {31'd0, push_valid}, 32'd1);

        // Reset during a break
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-break", {push_word, 13'd0, push_valid, abort_rx, break_active}, 32'd0);
        rx_line = 1'b1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule